// File: doc/BRIEF.md
# Three-Byte Serial ADC Conversion Sequencer

This block is the host side of one conversion on a serial analog-to-digital converter that takes a command byte and returns a 12-bit sample. A start request brings a five-bit channel/mode code. The block pulls chip select low and sends a command byte built from that code. It then sends two zero bytes, which clock the converter's result back. After the third byte it releases chip select. It presents the aligned result, widened to 16 bits, with a one-cycle valid pulse.

The serial clock idles low and is generated from the system clock. A run-time half-period setting sets its rate. The default widths cover 100 kHz to 2 MHz from a 50 MHz system clock. A run-time gap setting inserts idle system clocks between bytes. A cycle counter measures how long chip select stays low. If that time exceeds a parameterised limit, the counter flags the conversion, because the sampled value would have decayed.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, busy is 0, result_valid is 0 and timeout_err is 0.
- R2: A start while idle pulls cs_n low and raises busy. The block then sends a first byte equal to {1'b1, chan_mode[4:0], 2'b11}, most significant bit first. Exactly 24 rising sclk edges occur while cs_n is low.
- R3: The second and third bytes sent on mosi are 8'h00.
- R4: In every serial bit, sclk is high for H system clocks and low for at least H. H is half_div, and a half_div of 0 acts as 1. mosi does not change while sclk is high.
- R5: Between bytes, sclk stays low for at least gap_cycles + H system clocks.
- R6: miso is sampled at each sclk rising edge, most significant bit first. The first received byte is discarded. The 12-bit result is {byte2[6:0], byte3[7:3]}. Bit 7 of byte2 and bits 2:0 of byte3 are not used.
- R7: If bipolar was 0 at start, result[15:12] is zero. If bipolar was 1, result[15:12] repeats result[11].
- R8: In the cycle after the last sclk fall completes, cs_n returns high, busy drops and result_valid pulses for one cycle with the result.
- R9: A start while busy is ignored. It changes no byte sent and yields no extra result.
- R10: With result_valid, timeout_err is 1 only if cs_n was low for more than TMO_CYCLES system clocks. It holds that value until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one conversion |
| chan_mode | input | 5 | Channel/mode code placed in the command byte |
| bipolar | input | 1 | 1: sign-extend result, 0: zero-extend |
| half_div | input | DIV_W | System clocks per sclk half period (0 acts as 1) |
| gap_cycles | input | GAP_W | Idle system clocks inserted between bytes |
| miso | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the converter |
| busy | output | 1 | Conversion in progress |
| result_valid | output | 1 | One-cycle result strobe |
| result | output | 16 | Extended conversion result |
| timeout_err | output | 1 | Conversion exceeded the time limit |

## Verification
The bench keeps the default divider and gap widths but lowers TMO_CYCLES to 600. With that limit, a gap of a few hundred system clocks pushes a conversion over the limit, and a small gap keeps it under, so both timeout_err outcomes occur in short runs. Half periods of 0, 1, 2 and 3 exercise the zero-as-one rule and the exact high-time measurement. Response bytes with the unused bits set show that those bits are dropped and that bipolar sign extension works.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SETUP = 2'd1,
    SEQ_XFER  = 2'd2,
    SEQ_GAP   = 2'd3
  } seq_state_t;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_LO   = 2'd1,
    ENG_HI   = 2'd2
  } eng_state_t;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned CODE_W   = 5;
  localparam int unsigned SAMPLE_W = 12;
  localparam int unsigned OUT_W    = 16;
  localparam int unsigned N_BYTES  = 3;

  function automatic logic [BYTE_W-1:0] make_cmd(input logic [CODE_W-1:0] code);
    return {1'b1, code, 2'b11};
  endfunction

endpackage

// File: rtl/spi_byte_engine.sv
module spi_byte_engine
  import adc_seq_pkg::*;
#(
  parameter int unsigned DIV_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic [DIV_W-1:0]  half_div,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              done,
  output logic [BYTE_W-1:0] rx_byte
);

  localparam int unsigned BIT_W = $clog2(BYTE_W);

  eng_state_t        st_q, st_d;
  logic [DIV_W-1:0]  cnt_q, cnt_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic [BYTE_W-1:0] rx_q, rx_d;
  logic              sclk_q, sclk_d;
  logic              done_q, done_d;
  logic [DIV_W-1:0]  half_eff;
  logic              half_end;

  assign half_eff = (half_div == '0) ? DIV_W'(1) : half_div;
  assign half_end = (cnt_q == half_eff - DIV_W'(1));

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    sclk_d = sclk_q;
    done_d = 1'b0;
    unique case (st_q)
      ENG_IDLE: begin
        if (go) begin
          tx_d  = tx_byte;
          cnt_d = '0;
          bit_d = '0;
          st_d  = ENG_LO;
        end
      end
      ENG_LO: begin
        if (half_end) begin
          sclk_d = 1'b1;
          rx_d   = {rx_q[BYTE_W-2:0], miso};
          cnt_d  = '0;
          st_d   = ENG_HI;
        end else begin
          cnt_d = cnt_q + DIV_W'(1);
        end
      end
      ENG_HI: begin
        if (half_end) begin
          sclk_d = 1'b0;
          cnt_d  = '0;
          if (bit_q == BIT_W'(BYTE_W - 1)) begin
            done_d = 1'b1;
            st_d   = ENG_IDLE;
          end else begin
            bit_d = bit_q + BIT_W'(1);
            tx_d  = {tx_q[BYTE_W-2:0], 1'b0};
            st_d  = ENG_LO;
          end
        end else begin
          cnt_d = cnt_q + DIV_W'(1);
        end
      end
      default: st_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ENG_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      sclk_q <= sclk_d;
      done_q <= done_d;
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = tx_q[BYTE_W-1];
  assign done    = done_q;
  assign rx_byte = rx_q;

  // R4
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENG_HI && !half_end) |=> (sclk && $stable(mosi)));

  // R4
  lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENG_LO && !half_end) |=> !sclk);

endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
  parameter int unsigned TMO_CYCLES = 6000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic over
);

  localparam int unsigned CW  = $clog2(TMO_CYCLES + 2);
  localparam logic [CW-1:0] LIM = CW'(TMO_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (en && cnt_q <= LIM)
      cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign over = (cnt_q > LIM);

  // R10
  sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (over && !clr) |=> over);

endmodule

// File: rtl/result_pack.sv
module result_pack
  import adc_seq_pkg::*;
(
  input  logic [BYTE_W-1:0] hi_byte,
  input  logic [BYTE_W-1:0] lo_byte,
  input  logic              signed_mode,
  output logic [OUT_W-1:0]  word
);

  localparam int unsigned EXT_W = OUT_W - SAMPLE_W;

  logic [SAMPLE_W-1:0] sample;
  logic                fill;

  assign sample = {hi_byte[6:0], lo_byte[7:3]};
  assign fill   = signed_mode & sample[SAMPLE_W-1];
  assign word   = {{EXT_W{fill}}, sample};

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned DIV_W      = 9,
  parameter int unsigned GAP_W      = 12,
  parameter int unsigned TMO_CYCLES = 6000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [4:0]       chan_mode,
  input  logic             bipolar,
  input  logic [DIV_W-1:0] half_div,
  input  logic [GAP_W-1:0] gap_cycles,
  input  logic             miso,
  output logic             cs_n,
  output logic             sclk,
  output logic             mosi,
  output logic             busy,
  output logic             result_valid,
  output logic [15:0]      result,
  output logic             timeout_err
);

  localparam int unsigned IDX_W = $clog2(N_BYTES);

  seq_state_t        st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [GAP_W-1:0]  gcnt_q, gcnt_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              bip_q, bip_d;
  logic [BYTE_W-1:0] b2_q, b2_d;
  logic              cs_q, cs_d;
  logic              busy_q, busy_d;
  logic              vld_q, vld_d;
  logic [OUT_W-1:0]  res_q, res_d;
  logic              terr_q, terr_d;

  logic              eng_go;
  logic [BYTE_W-1:0] eng_tx;
  logic              eng_done;
  logic [BYTE_W-1:0] eng_rx;
  logic              tmr_clr;
  logic              tmr_over;
  logic [OUT_W-1:0]  packed_word;

  spi_byte_engine #(.DIV_W(DIV_W)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (eng_go),
    .tx_byte  (eng_tx),
    .half_div (half_div),
    .miso     (miso),
    .sclk     (sclk),
    .mosi     (mosi),
    .done     (eng_done),
    .rx_byte  (eng_rx)
  );

  conv_timer #(.TMO_CYCLES(TMO_CYCLES)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .en    (busy_q),
    .over  (tmr_over)
  );

  result_pack u_pack (
    .hi_byte     (b2_q),
    .lo_byte     (eng_rx),
    .signed_mode (bip_q),
    .word        (packed_word)
  );

  assign eng_tx = (idx_q == '0) ? make_cmd(code_q) : '0;

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    gcnt_d  = gcnt_q;
    code_d  = code_q;
    bip_d   = bip_q;
    b2_d    = b2_q;
    cs_d    = cs_q;
    busy_d  = busy_q;
    vld_d   = 1'b0;
    res_d   = res_q;
    terr_d  = terr_q;
    eng_go  = 1'b0;
    tmr_clr = 1'b0;
    unique case (st_q)
      SEQ_IDLE: begin
        if (start) begin
          code_d  = chan_mode;
          bip_d   = bipolar;
          idx_d   = '0;
          cs_d    = 1'b0;
          busy_d  = 1'b1;
          tmr_clr = 1'b1;
          st_d    = SEQ_SETUP;
        end
      end
      SEQ_SETUP: begin
        eng_go = 1'b1;
        st_d   = SEQ_XFER;
      end
      SEQ_XFER: begin
        if (eng_done) begin
          if (idx_q == IDX_W'(1))
            b2_d = eng_rx;
          if (idx_q == IDX_W'(N_BYTES - 1)) begin
            cs_d   = 1'b1;
            busy_d = 1'b0;
            vld_d  = 1'b1;
            res_d  = packed_word;
            terr_d = tmr_over;
            st_d   = SEQ_IDLE;
          end else begin
            idx_d  = idx_q + IDX_W'(1);
            gcnt_d = '0;
            st_d   = SEQ_GAP;
          end
        end
      end
      SEQ_GAP: begin
        if (gcnt_q == gap_cycles) begin
          eng_go = 1'b1;
          st_d   = SEQ_XFER;
        end else begin
          gcnt_d = gcnt_q + GAP_W'(1);
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      idx_q  <= '0;
      gcnt_q <= '0;
      code_q <= '0;
      bip_q  <= 1'b0;
      b2_q   <= '0;
      cs_q   <= 1'b1;
      busy_q <= 1'b0;
      vld_q  <= 1'b0;
      res_q  <= '0;
      terr_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      gcnt_q <= gcnt_d;
      code_q <= code_d;
      bip_q  <= bip_d;
      b2_q   <= b2_d;
      cs_q   <= cs_d;
      busy_q <= busy_d;
      vld_q  <= vld_d;
      res_q  <= res_d;
      terr_q <= terr_d;
    end
  end

  assign cs_n         = cs_q;
  assign busy         = busy_q;
  assign result_valid = vld_q;
  assign result       = res_q;
  assign timeout_err  = terr_q;

  // R4
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R2
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (cs_n && !busy && !sclk) ##1 !result_valid);

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(code_q) && $stable(bip_q)));

  // R7
  extend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (bip_q ? (result[15:12] == {4{result[11]}})
                            : (result[15:12] == 4'h0)));

endmodule

// File: tb/sim_adc_conv_seq.sv
module sim_adc_conv_seq;

  localparam int unsigned DIV_W = 9;
  localparam int unsigned GAP_W = 12;
  localparam int unsigned TMO   = 600;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [4:0]       chan_mode = '0;
  logic             bipolar = 1'b0;
  logic [DIV_W-1:0] half_div = '0;
  logic [GAP_W-1:0] gap_cycles = '0;
  logic             miso;
  logic             cs_n, sclk, mosi, busy, result_valid, timeout_err;
  logic [15:0]      result;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done_run = 1'b0;

  always #10 clk = ~clk;

  adc_conv_seq #(.DIV_W(DIV_W), .GAP_W(GAP_W), .TMO_CYCLES(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_mode(chan_mode),
    .bipolar(bipolar), .half_div(half_div), .gap_cycles(gap_cycles),
    .miso(miso), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .busy(busy),
    .result_valid(result_valid), .result(result), .timeout_err(timeout_err)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter model: presents bits on falling sclk, captures mosi on rising sclk
  logic [23:0] resp = '0;
  logic [23:0] shreg = '0;
  logic [23:0] seen = '0;
  int          rises = 0;
  assign miso = shreg[23];

  always @(negedge cs_n) begin
    shreg = resp;
    rises = 0;
  end
  always @(negedge sclk) if (!cs_n) shreg = {shreg[22:0], 1'b0};
  always @(posedge sclk) if (!cs_n) begin
    seen  = {seen[22:0], mosi};
    rises = rises + 1;
  end

  // timing monitor
  int cur_h = 1;
  int cur_gap = 0;
  int hi_run = 0;
  int lo_run = 0;
  int max_lo = 0;
  int hi_bad = 0;
  int min_lo = 1000000;
  always @(negedge clk) begin
    if (sclk) begin
      hi_run++;
      if (lo_run != 0 && lo_run < min_lo) min_lo = lo_run;
      if (lo_run > max_lo) max_lo = lo_run;
      lo_run = 0;
    end else begin
      if (hi_run != 0 && hi_run != cur_h) hi_bad++;
      hi_run = 0;
      if (!cs_n) lo_run++;
    end
  end

  // scoreboard
  typedef struct packed {
    logic [7:0]  cmd;
    logic [15:0] res;
    logic        terr;
  } exp_t;
  exp_t exp_q[$];
  int   results_seen = 0;

  always @(negedge clk) begin
    if (rst_n && result_valid) begin
      exp_t e;
      results_seen++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected result", 32'(result), 32'hFFFF);
      end else begin
        e = exp_q.pop_front();
        check(seen[23:16] == e.cmd, "R2 command byte", 32'(seen[23:16]), 32'(e.cmd));
        check(seen[15:0] == 16'h0000, "R3 zero bytes", 32'(seen[15:0]), 32'h0);
        check(rises == 24, "R2 sclk rising edges", 32'(rises), 32'd24);
        check(result == e.res, "R6 R7 result", 32'(result), 32'(e.res));
        check(timeout_err == e.terr, "R10 timeout flag", 32'(timeout_err), 32'(e.terr));
        check(cs_n && !busy, "R8 release with valid", {30'b0, cs_n, busy}, 32'h2);
        check(hi_bad == 0, "R4 sclk high time", 32'(hi_bad), 32'h0);
        check(min_lo >= cur_h, "R4 sclk low time", 32'(min_lo), 32'(cur_h));
        check(max_lo >= cur_gap + cur_h, "R5 inter-byte gap", 32'(max_lo),
              32'(cur_gap + cur_h));
      end
    end
  end

  task automatic convert(input logic [4:0] code, input bit bip, input int h,
                         input int gap, input logic [7:0] b2, input logic [7:0] b3,
                         input bit exp_terr, input bit poke);
    exp_t e;
    logic [11:0] s;
    s = {b2[6:0], b3[7:3]};
    e.cmd  = {1'b1, code, 2'b11};
    e.res  = bip ? {{4{s[11]}}, s} : {4'h0, s};
    e.terr = exp_terr;
    exp_q.push_back(e);
    @(negedge clk);
    resp       = {8'h5A, b2, b3};
    cur_h      = (h == 0) ? 1 : h;
    cur_gap    = gap;
    hi_bad     = 0;
    min_lo     = 1000000;
    max_lo     = 0;
    lo_run     = 0;
    chan_mode  = code;
    bipolar    = bip;
    half_div   = DIV_W'(h);
    gap_cycles = GAP_W'(gap);
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (20) @(negedge clk);
      chan_mode = ~code;
      bipolar   = ~bip;
      start     = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!result_valid) @(negedge clk);
    @(negedge clk);
    check(!result_valid, "R8 valid one cycle", 32'(result_valid), 32'h0);
    check(result == e.res, "R10 result held", 32'(result), 32'(e.res));
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cs_n == 1'b1, "R1 cs_n reset", 32'(cs_n), 32'h1);
    check(sclk == 1'b0, "R1 sclk reset", 32'(sclk), 32'h0);
    check(busy == 1'b0, "R1 busy reset", 32'(busy), 32'h0);
    check(result_valid == 1'b0 && timeout_err == 1'b0, "R1 valid/err reset",
          {30'b0, result_valid, timeout_err}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    convert(5'b00011, 1'b0, 2, 0,  8'h7F, 8'hF8, 1'b0, 1'b0); // full scale
    convert(5'b10100, 1'b1, 1, 5,  8'h40, 8'h00, 1'b0, 1'b0); // negative bipolar
    convert(5'b01010, 1'b1, 3, 2,  8'h15, 8'hA7, 1'b0, 1'b0); // positive bipolar
    convert(5'b11111, 1'b0, 0, 1,  8'hC0, 8'h0F, 1'b0, 1'b0); // R6 unused bits set, h=0
    convert(5'b00000, 1'b0, 2, 20, 8'h2B, 8'h6D, 1'b0, 1'b0); // under limit
    convert(5'b00110, 1'b1, 2, 300, 8'h7A, 8'h30, 1'b1, 1'b0); // R10 over limit
    convert(5'b01101, 1'b0, 2, 3,  8'h12, 8'h34, 1'b0, 1'b1); // R9 start while busy
    check(results_seen == 7, "R9 result count", 32'(results_seen), 32'd7);
    repeat (40) @(negedge clk);
    check(!busy && cs_n, "R9 idle after ignored start", {30'b0, busy, cs_n}, 32'h1);
    check(exp_q.size() == 0, "R8 all results delivered", 32'(exp_q.size()), 32'h0);
    done_run = 1'b1;
  end

  initial begin
    while (!done_run && cyc < 150000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done_run) check(1'b0, "watchdog expired", 32'(cyc), 32'd150000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule